// File: doc/BRIEF.md
# Byte-Wide EPROM Fetch Sequencer

This block reads configuration data out of an external byte-wide EPROM and turns it into a serial bit stream. A start request loads a byte count. The sequencer then walks a 16-bit address from zero upward. After each address step it waits a fixed number of access clocks and captures the byte on the 8-bit data bus. It then shifts that byte out most significant bit first, one bit per clock, with a qualifying strobe.

A separate read-clock output gives a one-cycle high pulse just before every address step. The address changes on the clock edge that ends the pulse, so external logic can count or latch on the rising edge of the read clock. The two lowest address bits are also copied onto two select outputs. The fetch stops when the requested number of bytes has been shifted. Done is then raised and the address freezes. If the count would carry the address past its all-ones value, the fetch stops with an error flag instead.

Top module: `eprom_fetch_seq`

## Requirements
- R1: While reset is low and on the first cycle after it, addr is 0 and rclk, ser_valid, done and err are all 0.
- R2: rclk is high for exactly one cycle at a time, and addr changes only on the clock edge that ends such a cycle, so every address change is preceded by a rising edge of rclk.
- R3: sel_a0 always equals addr bit 0 and sel_a1 always equals addr bit 1.
- R4: A start with a nonzero byte_count, sampled while the block is idle, done or in error, gives an rclk pulse in the next cycle and sets addr to 0 at the edge that ends the pulse. It also clears done and err. A start sampled during an active fetch has no effect.
- R5: After each address change the block waits ACCESS_WAIT cycles (default 4). It samples data_in on the edge that ends the last of those cycles and on no earlier edge.
- R6: Each sampled byte is shifted out on ser_data over DATA_W consecutive cycles, most significant bit first, with ser_valid high and rclk low throughout.
- R7: The k-th byte of a fetch, counting from zero, is read from address k. The address rises by exactly one between bytes.
- R8: With byte_count N > 0, done rises in the cycle after the last bit of byte N and stays high, with addr held at N-1 and no further rclk pulse, until the next start. With byte_count 0, a start raises done in the next cycle with no rclk pulse and no address change.
- R9: If a byte at the all-ones address finishes while bytes are still owed, err rises in the next cycle, done stays low, addr stays all-ones and no rclk pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Fetch request, sampled on each rising edge |
| byte_count | input | ADDR_W+1 | Number of bytes to fetch, latched at start |
| data_in | input | DATA_W | Byte from the EPROM |
| addr | output | ADDR_W | EPROM address |
| rclk | output | 1 | Read-clock pulse ahead of each address step |
| sel_a0 | output | 1 | Copy of addr bit 0 |
| sel_a1 | output | 1 | Copy of addr bit 1 |
| ser_data | output | 1 | Serial data, MSB first |
| ser_valid | output | 1 | High while ser_data carries a bit |
| done | output | 1 | Requested bytes delivered |
| err | output | 1 | Fetch stopped by address wrap |

## Verification
A start request can land in the cycle that carries the last serial bit of the final byte. That is the same cycle in which the sequencer decides to finish. The bench drives start in exactly that cycle for several fetch lengths. It then requires done to rise in the next cycle with no rclk pulse, no address change and no restart. A further run drives start in the middle of a fetch and requires the received byte stream to stay intact. The EPROM model in the bench returns the inverted byte until ACCESS_WAIT cycles have passed since the read-clock pulse, so sampling one edge early shows up as a wrong byte.

// File: rtl/eprom_fetch_seq.sv
module eprom_fetch_seq #(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 8,
  parameter int ACCESS_WAIT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W:0]   byte_count,
  input  logic [DATA_W-1:0] data_in,
  output logic [ADDR_W-1:0] addr,
  output logic              rclk,
  output logic              sel_a0,
  output logic              sel_a1,
  output logic              ser_data,
  output logic              ser_valid,
  output logic              done,
  output logic              err
);

  localparam int CNT_W  = ADDR_W + 1;
  localparam int WAIT_W = (ACCESS_WAIT > 1) ? $clog2(ACCESS_WAIT) : 1;
  localparam int BIT_W  = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  typedef enum logic [2:0] {S_IDLE, S_PULSE, S_WAIT, S_SHIFT, S_DONE, S_ERR} state_t;

  state_t              st;
  logic [ADDR_W-1:0]   nxt_addr;
  logic [CNT_W-1:0]    left;
  logic [WAIT_W-1:0]   wcnt;
  logic [BIT_W-1:0]    bcnt;
  logic [DATA_W-1:0]   shreg;

  wire idle_like = (st == S_IDLE) || (st == S_DONE) || (st == S_ERR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      addr     <= '0;
      nxt_addr <= '0;
      left     <= '0;
      wcnt     <= '0;
      bcnt     <= '0;
      shreg    <= '0;
    end else begin
      case (st)
        S_PULSE: begin
          addr <= nxt_addr;
          wcnt <= '0;
          st   <= S_WAIT;
        end
        S_WAIT: begin
          if (wcnt == WAIT_W'(ACCESS_WAIT - 1)) begin
            shreg <= data_in;
            bcnt  <= '0;
            st    <= S_SHIFT;
          end else begin
            wcnt <= wcnt + 1'b1;
          end
        end
        S_SHIFT: begin
          shreg <= shreg << 1;
          bcnt  <= bcnt + 1'b1;
          if (bcnt == BIT_W'(DATA_W - 1)) begin
            left <= left - 1'b1;
            if (left == CNT_W'(1))
              st <= S_DONE;
            else if (&addr)
              st <= S_ERR;
            else begin
              nxt_addr <= addr + 1'b1;
              st       <= S_PULSE;
            end
          end
        end
        default: begin
          if (idle_like && start) begin
            if (byte_count == '0)
              st <= S_DONE;
            else begin
              left     <= byte_count;
              nxt_addr <= '0;
              st       <= S_PULSE;
            end
          end
        end
      endcase
    end
  end

  assign rclk      = (st == S_PULSE);
  assign ser_valid = (st == S_SHIFT);
  assign ser_data  = ser_valid & shreg[DATA_W-1];
  assign done      = (st == S_DONE);
  assign err       = (st == S_ERR);
  assign sel_a0    = addr[0];
  assign sel_a1    = addr[1];

  AST_ADDR_AFTER_RCLK: assert property (@(posedge clk) disable iff (!rst_n)
    (addr != $past(addr)) |-> $past(rclk)); // R2
  AST_RCLK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rclk |=> !rclk); // R2
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (addr != $past(addr)) |-> (addr == $past(addr) + 1'b1 || addr == '0)); // R7
  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(done)) |-> ($stable(addr) && !rclk)); // R8
  AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> ($past(ser_valid) || $past(start))); // R8
  AST_WRAP_AT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> ((&addr) && $past(ser_valid))); // R9

endmodule

// File: tb/eprom_fetch_seq_tb_top.sv
module eprom_fetch_seq_tb_top;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [16:0] byte_count = '0;
  logic [7:0]  data_in;
  logic [15:0] addr;
  logic        rclk, sel_a0, sel_a1, ser_data, ser_valid, done, err;

  logic        wstart = 1'b0;
  logic [4:0]  wcount = '0;
  logic [3:0]  waddr;
  logic        wrclk, wsel0, wsel1, wdata, wvalid, wdone, werr;

  int n_chk = 0, n_fail = 0;
  int age = 0, rx_cnt = 0, rx_base = 0, nb = 0, rclk_seen = 0;
  logic        prev_rclk = 1'b0;
  logic [15:0] last_addr = '0;
  logic [7:0]  sh = '0;
  logic [7:0]  seed = '0;

  eprom_fetch_seq dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .byte_count(byte_count), .data_in(data_in),
    .addr(addr), .rclk(rclk), .sel_a0(sel_a0), .sel_a1(sel_a1), .ser_data(ser_data),
    .ser_valid(ser_valid), .done(done), .err(err));

  eprom_fetch_seq #(.ADDR_W(4)) wrap_i (
    .clk(clk), .rst_n(rst_n), .start(wstart), .byte_count(wcount), .data_in(8'h00),
    .addr(waddr), .rclk(wrclk), .sel_a0(wsel0), .sel_a1(wsel1), .ser_data(wdata),
    .ser_valid(wvalid), .done(wdone), .err(werr));

  function automatic logic [7:0] romf(input logic [15:0] a, input logic [7:0] s);
    return a[7:0] ^ a[15:8] ^ s ^ 8'h5A;
  endfunction

  assign data_in = (age >= 4) ? romf(addr, seed) : ~romf(addr, seed);

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_rclk) age = 1; else if (age < 1000) age = age + 1;
      if (addr !== last_addr) begin
        check(prev_rclk, "R2 addr change without prior rclk", 32'(addr), 32'(last_addr));
        last_addr = addr;
      end
      if (rclk) rclk_seen = rclk_seen + 1;
      if (ser_valid) begin
        check(!rclk, "R6 rclk low while shifting", 32'(rclk), 0);
        sh = {sh[6:0], ser_data};
        nb = nb + 1;
        if (nb == 8) begin
          nb = 0;
          check(sh == romf(16'(rx_cnt - rx_base), seed), "R5 R6 byte value", 32'(sh),
                32'(romf(16'(rx_cnt - rx_base), seed)));
          check(addr == 16'(rx_cnt - rx_base), "R7 byte address", 32'(addr), 32'(rx_cnt - rx_base));
          check(sel_a0 == addr[0] && sel_a1 == addr[1], "R3 select mirrors",
                {30'd0, sel_a1, sel_a0}, {30'd0, addr[1:0]});
          rx_cnt = rx_cnt + 1;
        end
      end
      prev_rclk = rclk;
    end
  end

  localparam logic [31:0] VEC [0:4] = '{
    {8'd0, 8'h00, 16'd1},
    {8'd1, 8'hA5, 16'd3},
    {8'd2, 8'h3C, 16'd5},
    {8'd2, 8'hFF, 16'd2},
    {8'd0, 8'h11, 16'd4}
  };

  task automatic run_vec(input int n, input logic [7:0] s, input int mode);
    int seen;
    logic [15:0] held;
    seed = s;
    rx_base = rx_cnt;
    @(negedge clk); byte_count = 17'(n); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(rclk == 1'b1, "R4 pulse after start", 32'(rclk), 1);
    check(done == 1'b0, "R4 done cleared", 32'(done), 0);
    for (int c = 2; c <= 13 * n; c++) begin
      @(negedge clk);
      if (c == 2) check(addr == 16'd0, "R4 address restarts at zero", 32'(addr), 0);
      start = ((mode == 1 && c == 7) || (mode == 2 && c == 13 * n));
    end
    check(done == 1'b0, "R8 done not early", 32'(done), 0);
    @(negedge clk); start = 1'b0;
    check(done == 1'b1, "R8 done after last bit", 32'(done), 1);
    check(err == 1'b0, "R8 no error", 32'(err), 0);
    check(rclk == 1'b0, "R4 start on last bit ignored", 32'(rclk), 0);
    check(rx_cnt - rx_base == n, "R8 byte total", 32'(rx_cnt - rx_base), 32'(n));
    check(addr == 16'(n - 1), "R7 final address", 32'(addr), 32'(n - 1));
    seen = rclk_seen;
    held = addr;
    repeat (6) @(negedge clk);
    check(done && addr == held && rclk_seen == seen, "R8 halted after done",
          {15'd0, done, addr}, {15'd0, 1'b1, held});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(addr == 0 && !rclk && !ser_valid && !done && !err, "R1 state in reset",
          {addr, 11'd0, rclk, ser_valid, done, err}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(addr == 0 && !rclk && !ser_valid && !done && !err, "R1 state after reset",
          {addr, 11'd0, rclk, ser_valid, done, err}, 0);

    byte_count = '0; start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(done == 1'b1 && rclk == 1'b0 && addr == 0, "R8 zero count",
          {14'd0, done, rclk, addr}, {14'd0, 2'b10, 16'd0});

    for (int i = 0; i < 5; i++)
      run_vec(int'(VEC[i][15:0]), VEC[i][23:16], int'(VEC[i][31:24]));

    @(negedge clk); wcount = 5'd18; wstart = 1'b1;
    @(negedge clk); wstart = 1'b0;
    repeat (16 * 13 - 1) @(negedge clk);
    check(werr == 1'b0, "R9 no early error", 32'(werr), 0);
    @(negedge clk);
    check(werr == 1'b1 && wdone == 1'b0, "R9 error on wrap", {30'd0, werr, wdone}, 32'b10);
    check(waddr == 4'hF && wrclk == 1'b0, "R9 address held at top", {27'd0, wrclk, waddr}, 32'hF);
    @(negedge clk);
    check(wrclk == 1'b0 && waddr == 4'hF, "R9 no pulse after error", {27'd0, wrclk, waddr}, 32'hF);
    wcount = 5'd1; wstart = 1'b1;
    @(negedge clk); wstart = 1'b0;
    check(wrclk == 1'b1 && werr == 1'b0, "R4 restart from error", {30'd0, wrclk, werr}, 32'b10);
    @(negedge clk);
    check(waddr == 4'h0, "R4 restart address", 32'(waddr), 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule